// File: doc/BRIEF.md
# E-paper gate row sequencer

This block drives the vertical scan of an electrophoretic panel's gate shift register. It produces three panel-side signals: a gate output enable, an active-low start pulse and a row clock. A controller sends it one command at a time over a valid/ready handshake. Each accepted command produces exactly one row-clock period. The high time and the low time of that period depend on the command. The low time is always much longer than the high time, so that charge left on the other rows can drain away.

A frame begins with a start command. This raises the gate enable and holds the start pulse low for one full row-clock period, which shifts a single 1 into the gate register. Write, skip and clear commands then step that 1 down the panel with the start pulse high. An end command produces one more short pulse, after which the gate enable falls. During the high phase of a write or a clear, the block raises a row strobe so that the source driver can raise its output enable at the same moment. A one-cycle done pulse marks the end of each command.

Durations are given in microseconds. They are counted from a tick that the block derives from the system clock frequency parameter, so one microsecond is CLK_HZ/1e6 clock cycles.

Top module: `gate_row_seq`

## Requirements
- R1: After reset, gate_start_n is 1, and row_clk, row_oe, gate_en, done and busy are 0, while cmd_ready is 1.
- R2: A command is taken only on a clock edge where cmd_valid and cmd_ready are both 1. busy is 1 from the next cycle until the command ends. While busy, cmd_ready is 0 and any held command waits without effect. A command held valid is taken on the edge right after the done cycle.
- R3: Start (code 0) raises gate_en and drives gate_start_n low on the same edge that row_clk rises. gate_start_n stays low through the whole high and low phase and returns to 1 together with done.
- R4: Every command other than start leaves gate_start_n at 1 for its whole duration.
- R5: Write (code 1) holds row_clk high for WRITE_HI_US and then low for WRITE_LO_US (default 5 and 200 µs), each µs being CLK_HZ/1e6 cycles.
- R6: Skip (code 2) holds row_clk high for SKIP_HI_US and then low for SKIP_LO_US (default 1 and 100 µs).
- R7: Clear (code 3) holds row_clk high for CLEAR_HI_US and then low for CLEAR_LO_US (default 20 and 200 µs).
- R8: Start and end (code 4) hold row_clk high for FRAME_HI_US and then low for FRAME_LO_US (default 1 and 4 µs).
- R9: row_oe is 1 for exactly the cycles in which row_clk is high during a write or a clear. It stays 0 for start, skip and end.
- R10: gate_en falls on the edge that ends the low phase of an end command, and only then.
- R11: done is 1 for the single cycle after the low phase ends. In that cycle row_clk is 0 and cmd_ready is already 1.
- R12: Codes 5 to 7 are taken and give done on the next cycle. They produce no row-clock pulse and change no other output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle; command taken when valid is also 1 |
| cmd_code | input | 3 | 0 start, 1 write, 2 skip, 3 clear, 4 end |
| gate_en | output | 1 | Gate driver output enable |
| gate_start_n | output | 1 | Active-low vertical start pulse |
| row_clk | output | 1 | Gate shift clock; rows are driven while high |
| row_oe | output | 1 | Strobe for the source output enable |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle end-of-command pulse |

## Verification
The done cycle of one command and the acceptance of the next can fall together. cmd_ready is already 1 while done is shown, so a command that has been held valid is taken on the very next edge. The bench provokes this by holding a start command valid and then changing the code to end while the sequencer is busy. It then checks three things: the end command did not disturb the running start, done lasted one cycle with row_clk low, and row_clk rose on the edge right after it. A behavioural cycle model, compared on every clock, judges the same overlap, as well as the gate enable drop that follows.

// File: rtl/gs_pkg.sv
package gs_pkg;

   typedef enum logic [2:0] {
      GS_START = 3'd0,
      GS_WRITE = 3'd1,
      GS_SKIP  = 3'd2,
      GS_CLEAR = 3'd3,
      GS_END   = 3'd4
   } gs_cmd_e;

   typedef enum logic [1:0] {
      GS_IDLE = 2'd0,
      GS_HIGH = 2'd1,
      GS_LOW  = 2'd2
   } gs_state_e;

   function automatic int unsigned gs_max(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/gs_cmd_decode.sv
module gs_cmd_decode
   import gs_pkg::*;
#(
   parameter int unsigned W           = 8,
   parameter int unsigned FRAME_HI_US = 1,
   parameter int unsigned FRAME_LO_US = 4,
   parameter int unsigned WRITE_HI_US = 5,
   parameter int unsigned WRITE_LO_US = 200,
   parameter int unsigned SKIP_HI_US  = 1,
   parameter int unsigned SKIP_LO_US  = 100,
   parameter int unsigned CLEAR_HI_US = 20,
   parameter int unsigned CLEAR_LO_US = 200
) (
   input  logic [2:0]   code,
   output logic         known,
   output logic         starts_frame,
   output logic         ends_frame,
   output logic         drives_oe,
   output logic [W-1:0] hi_us,
   output logic [W-1:0] lo_us
);

   always_comb begin
      known        = 1'b1;
      starts_frame = 1'b0;
      ends_frame   = 1'b0;
      drives_oe    = 1'b0;
      hi_us        = '0;
      lo_us        = '0;
      case (code)
         GS_START: begin
            starts_frame = 1'b1;
            hi_us        = W'(FRAME_HI_US);
            lo_us        = W'(FRAME_LO_US);
         end
         GS_WRITE: begin
            drives_oe = 1'b1;
            hi_us     = W'(WRITE_HI_US);
            lo_us     = W'(WRITE_LO_US);
         end
         GS_SKIP: begin
            hi_us = W'(SKIP_HI_US);
            lo_us = W'(SKIP_LO_US);
         end
         GS_CLEAR: begin
            drives_oe = 1'b1;
            hi_us     = W'(CLEAR_HI_US);
            lo_us     = W'(CLEAR_LO_US);
         end
         GS_END: begin
            ends_frame = 1'b1;
            hi_us      = W'(FRAME_HI_US);
            lo_us      = W'(FRAME_LO_US);
         end
         default: known = 1'b0;
      endcase
   end

endmodule

// File: rtl/gs_phase_timer.sv
module gs_phase_timer #(
   parameter int unsigned DIV = 50,
   parameter int unsigned W   = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_us,
   output logic         expired
);

   logic         running;
   logic [W-1:0] remain;
   logic         tick;

   generate
      if (DIV > 1) begin : g_prescale
         localparam int unsigned PW = $clog2(DIV);
         logic [PW-1:0] pre;
         always_ff @(posedge clk) begin
            if (!rst_n)             pre <= '0;
            else if (load || tick)  pre <= '0;
            else if (running)       pre <= pre + 1'b1;
         end
         assign tick = running && (pre == PW'(DIV - 1));
      end else begin : g_direct
         assign tick = running;
      end
   endgenerate

   assign expired = tick && (remain == W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         running <= 1'b0;
         remain  <= '0;
      end else if (load) begin
         running <= 1'b1;
         remain  <= load_us;
      end else if (tick) begin
         if (remain == W'(1)) running <= 1'b0;
         else                 remain  <= remain - 1'b1;
      end
   end

   assert_remain_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      running |-> (remain != '0));

   assert_load_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> (load_us != '0));

endmodule

// File: rtl/gate_row_seq.sv
module gate_row_seq
   import gs_pkg::*;
#(
   parameter int unsigned CLK_HZ      = 50_000_000,
   parameter int unsigned FRAME_HI_US = 1,
   parameter int unsigned FRAME_LO_US = 4,
   parameter int unsigned WRITE_HI_US = 5,
   parameter int unsigned WRITE_LO_US = 200,
   parameter int unsigned SKIP_HI_US  = 1,
   parameter int unsigned SKIP_LO_US  = 100,
   parameter int unsigned CLEAR_HI_US = 20,
   parameter int unsigned CLEAR_LO_US = 200
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_valid,
   output logic       cmd_ready,
   input  logic [2:0] cmd_code,
   output logic       gate_en,
   output logic       gate_start_n,
   output logic       row_clk,
   output logic       row_oe,
   output logic       busy,
   output logic       done
);

   localparam int unsigned DIV    = CLK_HZ / 1_000_000;
   localparam int unsigned MAX_US = gs_max(gs_max(FRAME_LO_US, WRITE_LO_US),
                                           gs_max(SKIP_LO_US, CLEAR_LO_US));
   localparam int unsigned W      = $clog2(MAX_US + 1);

   generate
      if (CLK_HZ < 1_000_000 || (CLK_HZ % 1_000_000) != 0) begin : g_bad_clk
         $fatal(1, "CLK_HZ must be a whole number of MHz");
      end
      if (FRAME_HI_US == 0 || FRAME_LO_US <= FRAME_HI_US) begin : g_bad_frame
         $fatal(1, "frame pulse needs nonzero high and longer low");
      end
      if (WRITE_HI_US == 0 || WRITE_LO_US <= WRITE_HI_US) begin : g_bad_write
         $fatal(1, "write pulse needs nonzero high and longer low");
      end
      if (SKIP_HI_US == 0 || SKIP_LO_US <= SKIP_HI_US) begin : g_bad_skip
         $fatal(1, "skip pulse needs nonzero high and longer low");
      end
      if (CLEAR_HI_US == 0 || CLEAR_LO_US <= CLEAR_HI_US) begin : g_bad_clear
         $fatal(1, "clear pulse needs nonzero high and longer low");
      end
   endgenerate

   gs_state_e    state;
   gs_cmd_e      cur;
   logic [2:0]   sel_code;
   logic         known, starts_frame, ends_frame, drives_oe;
   logic [W-1:0] hi_us, lo_us;
   logic         accept, load, expired;
   logic [W-1:0] load_us;

   assign cmd_ready = (state == GS_IDLE);
   assign busy      = (state != GS_IDLE);
   assign accept    = cmd_valid && cmd_ready;
   assign sel_code  = (state == GS_IDLE) ? cmd_code : 3'(cur);

   gs_cmd_decode #(
      .W(W),
      .FRAME_HI_US(FRAME_HI_US), .FRAME_LO_US(FRAME_LO_US),
      .WRITE_HI_US(WRITE_HI_US), .WRITE_LO_US(WRITE_LO_US),
      .SKIP_HI_US(SKIP_HI_US),   .SKIP_LO_US(SKIP_LO_US),
      .CLEAR_HI_US(CLEAR_HI_US), .CLEAR_LO_US(CLEAR_LO_US)
   ) u_dec (
      .code(sel_code),
      .known(known),
      .starts_frame(starts_frame),
      .ends_frame(ends_frame),
      .drives_oe(drives_oe),
      .hi_us(hi_us),
      .lo_us(lo_us)
   );

   assign load    = (accept && known) || (state == GS_HIGH && expired);
   assign load_us = (state == GS_HIGH) ? lo_us : hi_us;

   gs_phase_timer #(.DIV(DIV), .W(W)) u_tmr (
      .clk(clk),
      .rst_n(rst_n),
      .load(load),
      .load_us(load_us),
      .expired(expired)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state        <= GS_IDLE;
         cur          <= GS_START;
         row_clk      <= 1'b0;
         row_oe       <= 1'b0;
         gate_start_n <= 1'b1;
         gate_en      <= 1'b0;
         done         <= 1'b0;
      end else begin
         done <= 1'b0;
         case (state)
            GS_IDLE: begin
               if (accept) begin
                  if (known) begin
                     cur     <= gs_cmd_e'(cmd_code);
                     state   <= GS_HIGH;
                     row_clk <= 1'b1;
                     row_oe  <= drives_oe;
                     if (starts_frame) begin
                        gate_start_n <= 1'b0;
                        gate_en      <= 1'b1;
                     end
                  end else begin
                     done <= 1'b1;
                  end
               end
            end
            GS_HIGH: begin
               if (expired) begin
                  row_clk <= 1'b0;
                  row_oe  <= 1'b0;
                  state   <= GS_LOW;
               end
            end
            GS_LOW: begin
               if (expired) begin
                  state        <= GS_IDLE;
                  done         <= 1'b1;
                  gate_start_n <= 1'b1;
                  if (ends_frame) gate_en <= 1'b0;
               end
            end
            default: state <= GS_IDLE;
         endcase
      end
   end

   assert_oe_inside_clk_R9: assert property (@(posedge clk) disable iff (!rst_n)
      row_oe |-> row_clk);

   assert_start_needs_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !gate_start_n |-> gate_en);

   assert_start_only_on_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !gate_start_n |-> (cur == GS_START));

   assert_clk_rise_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(row_clk) |-> busy);

   assert_cmd_held_while_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(cur));

   assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!row_clk && cmd_ready));

   assert_enable_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(gate_en) |-> (done && cur == GS_END));

endmodule

// File: tb/sim_gate_row_seq.sv
module sim_gate_row_seq;

   localparam int CLK_HZ = 4_000_000;
   localparam int DIV    = CLK_HZ / 1_000_000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_valid = 1'b0;
   logic [2:0] cmd_code = 3'd0;
   logic       cmd_ready, gate_en, gate_start_n, row_clk, row_oe, busy, done;

   int errors = 0;
   int checks = 0;
   int cycles = 0;
   bit model_on = 1'b0;

   always #10 clk = ~clk;

   gate_row_seq #(.CLK_HZ(CLK_HZ)) u0 (
      .clk(clk), .rst_n(rst_n),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_code(cmd_code),
      .gate_en(gate_en), .gate_start_n(gate_start_n), .row_clk(row_clk),
      .row_oe(row_oe), .busy(busy), .done(done)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
      end
   endtask

   function automatic int hi_of(input int c);
      case (c)
         1: return 5;  2: return 1;  3: return 20;  default: return 1;
      endcase
   endfunction

   function automatic int lo_of(input int c);
      case (c)
         1: return 200;  2: return 100;  3: return 200;  default: return 4;
      endcase
   endfunction

   function automatic string tag_of(input int c);
      case (c)
         1: return "R5";  2: return "R6";  3: return "R7";  default: return "R8";
      endcase
   endfunction

   // behavioural reference model, stepped each rising edge
   int m_phase = 0, m_cnt = 0, m_cur = 0;
   int m_clk = 0, m_oe = 0, m_spv = 1, m_en = 0, m_done = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_phase = 0; m_cnt = 0; m_cur = 0;
         m_clk = 0; m_oe = 0; m_spv = 1; m_en = 0; m_done = 0;
      end else begin
         m_done = 0;
         if (m_phase == 0) begin
            if (cmd_valid) begin
               if (int'(cmd_code) <= 4) begin
                  m_cur = int'(cmd_code);
                  m_phase = 1;
                  m_cnt = hi_of(m_cur) * DIV;
                  m_clk = 1;
                  m_oe = (m_cur == 1 || m_cur == 3) ? 1 : 0;
                  if (m_cur == 0) begin m_spv = 0; m_en = 1; end
               end else begin
                  m_done = 1;
               end
            end
         end else if (m_phase == 1) begin
            m_cnt--;
            if (m_cnt == 0) begin
               m_clk = 0; m_oe = 0; m_phase = 2;
               m_cnt = lo_of(m_cur) * DIV;
            end
         end else begin
            m_cnt--;
            if (m_cnt == 0) begin
               m_phase = 0; m_done = 1; m_spv = 1;
               if (m_cur == 4) m_en = 0;
            end
         end
      end
   end

   always @(negedge clk) begin
      cycles++;
      if (model_on) begin
         chk(tag_of(m_cur), int'(row_clk), m_clk);
         chk("R9",  int'(row_oe), m_oe);
         chk("R3",  int'(gate_start_n), m_spv);
         chk("R10", int'(gate_en), m_en);
         chk("R11", int'(done), m_done);
         chk("R2",  int'(cmd_ready), (m_phase == 0) ? 1 : 0);
         chk("R2",  int'(busy), (m_phase != 0) ? 1 : 0);
      end
      if (cycles > 150000) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cycles);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   task automatic run_cmd(input int code);
      int hi = 0, lo = 0, spv = 0, oe = 0;
      @(negedge clk);
      while (!cmd_ready) @(negedge clk);
      cmd_valid = 1'b1;
      cmd_code  = 3'(code);
      @(negedge clk);
      cmd_valid = 1'b0;
      while (row_clk && hi < 100000) begin
         hi++;
         if (!gate_start_n) spv++;
         if (row_oe) oe++;
         @(negedge clk);
      end
      while (!done && lo < 100000) begin
         lo++;
         if (!gate_start_n) spv++;
         @(negedge clk);
      end
      chk(tag_of(code), hi, hi_of(code) * DIV);
      chk(tag_of(code), lo, lo_of(code) * DIV);
      if (code == 0) chk("R3", spv, (hi_of(0) + lo_of(0)) * DIV);
      else           chk("R4", spv, 0);
      chk("R9", oe, (code == 1 || code == 3) ? hi_of(code) * DIV : 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset levels
      chk("R1", int'(gate_start_n), 1);
      chk("R1", int'(row_clk), 0);
      chk("R1", int'(row_oe), 0);
      chk("R1", int'(gate_en), 0);
      chk("R1", int'(busy), 0);
      chk("R1", int'(done), 0);
      chk("R1", int'(cmd_ready), 1);
      rst_n = 1'b1;
      model_on = 1'b1;

      run_cmd(0);
      chk("R3", int'(gate_en), 1);
      run_cmd(1);
      run_cmd(2);
      run_cmd(3);
      run_cmd(1);

      // R12: unknown code inside a frame
      @(negedge clk);
      while (!cmd_ready) @(negedge clk);
      cmd_valid = 1'b1;
      cmd_code  = 3'd6;
      @(negedge clk);
      cmd_valid = 1'b0;
      chk("R12", int'(done), 1);
      chk("R12", int'(row_clk), 0);
      chk("R12", int'(busy), 0);
      chk("R12", int'(gate_en), 1);
      chk("R12", int'(gate_start_n), 1);

      run_cmd(4);
      chk("R10", int'(gate_en), 0);

      // R2/R11: held command taken right after done
      @(negedge clk);
      cmd_valid = 1'b1;
      cmd_code  = 3'd0;
      @(negedge clk);
      chk("R2", int'(busy), 1);
      cmd_code = 3'd4;
      @(negedge clk);
      chk("R2", int'(cmd_ready), 0);
      while (!done) @(negedge clk);
      chk("R11", int'(cmd_ready), 1);
      chk("R11", int'(row_clk), 0);
      chk("R3", int'(gate_start_n), 1);
      @(negedge clk);
      chk("R2", int'(row_clk), 1);
      chk("R2", int'(busy), 1);
      chk("R11", int'(done), 0);
      cmd_valid = 1'b0;
      while (!done) @(negedge clk);
      chk("R10", int'(gate_en), 0);
      chk("R4", int'(gate_start_n), 1);

      repeat (4) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule